// File: doc/BRIEF.md
# Paged Memory Region Decoder

This block sits beside one processor subsystem and turns each access it issues into a region select. A program access carries a 7-bit page extension and a 16-bit offset. The block sends it to one of four places: the subsystem's local dual-access RAM, the program RAM shared between subsystems, the boot ROM, or the external bus. Data and I/O accesses each use a single 64K-word page and are decoded by their own rules. Five mode inputs steer the result: overlay enable, microprocessor/microcomputer select, data-RAM enable, ROM overlay and external-bus enable.

For every access the block reports a one-hot region select and the index of the 8K-word block within that region. It also raises three flags: one for a refused write, one for an external access while the external bus is disabled, and one for a write that may take effect. The RAM arrays, the bus timing and the DMA engine lie outside the block.

The decode is a control path rather than a data stream, so the pins stay plain and there is no handshake. The caller presents an access and reads the decode one clock later (`REG_OUT=1`, the default), or in the same cycle (`REG_OUT=0`).

Top module: `pgmem_region_dec`

## Requirements
- R1: `region_sel` is one-hot. Its bits are: 0 local dual-access RAM, 1 local single-access RAM, 2 shared program RAM, 3 boot ROM, 4 external, 5 memory-mapped registers, 6 reserved. With `REG_OUT=1` the outputs follow the inputs one clock later. During reset they show external, block 0 and all flags low.
- R2: `acc_space` code 0 selects program space, 1 selects data space, and 2 and 3 select I/O space.
- R3: A program offset below 0x8000 decodes as external when overlay is 0, whatever the page. When overlay is 1 it decodes as local dual-access RAM, except that offsets 0x0000–0x005F decode as reserved.
- R4: A program offset of 0x8000 or above on pages 0–3 decodes as shared program RAM when `mode_mpmc`=0. It decodes as external when `mode_mpmc`=1 or when the page is 4 or more.
- R5: Pages 8–127 decode exactly as the external pages 4–7 do, so their upper half is always external.
- R6: With `mode_romen`=1, `mode_mpmc`=0, page 0 and an offset of 0xE000 or above, the access decodes as boot ROM. With `mode_romen`=0 the same access decodes as shared program RAM.
- R7: In data space the page is ignored. Offsets 0x0000–0x005F decode as registers and the rest below 0x8000 as local dual-access RAM. The upper half decodes as single-access RAM when `mode_drom`=1 and as external when it is 0.
- R8: I/O space always decodes as external, whatever the page, offset or modes.
- R9: `block_idx` is offset[14:13] for local dual-access and single-access RAM. For shared RAM it is {page[1:0], offset[14:13]}. For every other region it is 0.
- R10: `write_blocked` is 1 for a write to boot ROM, or for a CPU write (`acc_dma`=0) to shared RAM. A DMA write to shared RAM is not blocked.
- R11: `ext_off` is 1 when the access decodes as external and `mode_xio`=0, for reads and writes alike.
- R12: `write_commit` is 1 only for a write that is not blocked, not flagged by `ext_off` and not to a reserved range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_space | input | 2 | Address space: 0 program, 1 data, 2/3 I/O |
| acc_page | input | 7 | Program page extension |
| acc_offset | input | 16 | Word offset within the page |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_dma | input | 1 | 1 when the DMA engine issues the access, 0 for the CPU |
| mode_ovly | input | 1 | Maps local dual-access RAM into the lower half of program space |
| mode_mpmc | input | 1 | 1 makes the upper half of program space external |
| mode_drom | input | 1 | Enables single-access RAM in the upper half of data space |
| mode_romen | input | 1 | Overlays boot ROM on page 0, 0xE000–0xFFFF |
| mode_xio | input | 1 | External bus enable |
| region_sel | output | 7 | One-hot region select |
| block_idx | output | 4 | 8K-word block index within the region |
| write_blocked | output | 1 | Write refused by the region |
| ext_off | output | 1 | External access while the bus is disabled |
| write_commit | output | 1 | Write allowed to take effect |

## Verification
The assertions assume that every input is known and held steady across the sampling edge. They also assume that, after reset, each decode is observed against the access captured one edge earlier. The bench meets this by changing inputs only at falling edges and reading outputs at the next falling edge. It covers every page value, all 32 mode combinations and each region boundary offset, including the unused space code 3. A reference model in the bench, written from the rules above, supplies the expected values.

// File: rtl/pgmem_pkg.sv
`timescale 1ns/1ps
package pgmem_pkg;
  localparam int NREG = 7;
  localparam int RG_LDA = 0;
  localparam int RG_LSA = 1;
  localparam int RG_SHR = 2;
  localparam int RG_ROM = 3;
  localparam int RG_EXT = 4;
  localparam int RG_MMR = 5;
  localparam int RG_RSV = 6;
  typedef logic [NREG-1:0] region_vec_t;
  typedef enum logic [1:0] {
    SP_PROG = 2'd0,
    SP_DATA = 2'd1,
    SP_IO   = 2'd2,
    SP_IO2  = 2'd3
  } space_e;
endpackage

// File: rtl/pgmem_prog_dec.sv
`timescale 1ns/1ps
module pgmem_prog_dec
  import pgmem_pkg::*;
#(
  parameter int PAGE_W    = 7,
  parameter int OFF_W     = 16,
  parameter int BLK_W     = 13,
  parameter int INT_PAGES = 4,
  parameter int MMR_END   = 'h60,
  parameter int ROM_BASE  = 'hE000,
  localparam int SH_W     = $clog2(INT_PAGES),
  localparam int LOC_W    = OFF_W - 1 - BLK_W,
  localparam int IDX_W    = SH_W + LOC_W
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [OFF_W-1:0]  offset,
  input  logic              ovly,
  input  logic              mpmc,
  input  logic              romen,
  output region_vec_t       sel,
  output logic [IDX_W-1:0]  blk
);
  logic upper, page_int, page_zero, in_rom, in_rsv;

  always_comb begin
    upper     = offset[OFF_W-1];
    page_int  = (page < PAGE_W'(INT_PAGES));
    page_zero = (page == '0);
    in_rom    = (offset >= OFF_W'(ROM_BASE));
    in_rsv    = (offset < OFF_W'(MMR_END));
  end

  always_comb begin
    sel = '0;
    blk = '0;
    if (!upper) begin
      if (!ovly) begin
        sel[RG_EXT] = 1'b1;
      end else if (in_rsv) begin
        sel[RG_RSV] = 1'b1;
      end else begin
        sel[RG_LDA] = 1'b1;
        blk = IDX_W'(offset[OFF_W-2:BLK_W]);
      end
    end else if (mpmc || !page_int) begin
      sel[RG_EXT] = 1'b1;
    end else if (romen && page_zero && in_rom) begin
      sel[RG_ROM] = 1'b1;
    end else begin
      sel[RG_SHR] = 1'b1;
      blk = {page[SH_W-1:0], offset[OFF_W-2:BLK_W]};
    end
  end
endmodule

// File: rtl/pgmem_data_dec.sv
`timescale 1ns/1ps
module pgmem_data_dec
  import pgmem_pkg::*;
#(
  parameter int OFF_W   = 16,
  parameter int BLK_W   = 13,
  parameter int IDX_W   = 4,
  parameter int MMR_END = 'h60
) (
  input  logic             is_io,
  input  logic [OFF_W-1:0] offset,
  input  logic             drom,
  output region_vec_t      sel,
  output logic [IDX_W-1:0] blk
);
  always_comb begin
    sel = '0;
    blk = '0;
    if (is_io) begin
      sel[RG_EXT] = 1'b1;
    end else if (offset < OFF_W'(MMR_END)) begin
      sel[RG_MMR] = 1'b1;
    end else if (!offset[OFF_W-1]) begin
      sel[RG_LDA] = 1'b1;
      blk = IDX_W'(offset[OFF_W-2:BLK_W]);
    end else if (drom) begin
      sel[RG_LSA] = 1'b1;
      blk = IDX_W'(offset[OFF_W-2:BLK_W]);
    end else begin
      sel[RG_EXT] = 1'b1;
    end
  end
endmodule

// File: rtl/pgmem_access_qual.sv
`timescale 1ns/1ps
module pgmem_access_qual
  import pgmem_pkg::*;
(
  input  region_vec_t sel,
  input  logic        write,
  input  logic        dma,
  input  logic        xio,
  output logic        wblk,
  output logic        eoff,
  output logic        wcommit
);
  always_comb begin
    wblk    = write && (sel[RG_ROM] || (sel[RG_SHR] && !dma));
    eoff    = sel[RG_EXT] && !xio;
    wcommit = write && !wblk && !eoff && !sel[RG_RSV];
  end
endmodule

// File: rtl/pgmem_region_dec.sv
`timescale 1ns/1ps
module pgmem_region_dec
  import pgmem_pkg::*;
#(
  parameter int PAGE_W    = 7,
  parameter int OFF_W     = 16,
  parameter int BLK_W     = 13,
  parameter int INT_PAGES = 4,
  parameter int MMR_END   = 'h60,
  parameter int ROM_BASE  = 'hE000,
  parameter bit REG_OUT   = 1'b1,
  localparam int IDX_W    = $clog2(INT_PAGES) + OFF_W - 1 - BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        acc_space,
  input  logic [PAGE_W-1:0] acc_page,
  input  logic [OFF_W-1:0]  acc_offset,
  input  logic              acc_write,
  input  logic              acc_dma,
  input  logic              mode_ovly,
  input  logic              mode_mpmc,
  input  logic              mode_drom,
  input  logic              mode_romen,
  input  logic              mode_xio,
  output logic [NREG-1:0]   region_sel,
  output logic [IDX_W-1:0]  block_idx,
  output logic              write_blocked,
  output logic              ext_off,
  output logic              write_commit
);
  region_vec_t      p_sel, d_sel, c_sel;
  logic [IDX_W-1:0] p_blk, d_blk, c_blk;
  logic             c_wblk, c_eoff, c_wcom;
  space_e           space;

  assign space = space_e'(acc_space);

  pgmem_prog_dec #(
    .PAGE_W(PAGE_W), .OFF_W(OFF_W), .BLK_W(BLK_W), .INT_PAGES(INT_PAGES),
    .MMR_END(MMR_END), .ROM_BASE(ROM_BASE)
  ) u_prog (
    .page(acc_page), .offset(acc_offset), .ovly(mode_ovly), .mpmc(mode_mpmc),
    .romen(mode_romen), .sel(p_sel), .blk(p_blk)
  );

  pgmem_data_dec #(
    .OFF_W(OFF_W), .BLK_W(BLK_W), .IDX_W(IDX_W), .MMR_END(MMR_END)
  ) u_data (
    .is_io(space == SP_IO || space == SP_IO2), .offset(acc_offset),
    .drom(mode_drom), .sel(d_sel), .blk(d_blk)
  );

  always_comb begin
    if (space == SP_PROG) begin
      c_sel = p_sel;
      c_blk = p_blk;
    end else begin
      c_sel = d_sel;
      c_blk = d_blk;
    end
  end

  pgmem_access_qual u_qual (
    .sel(c_sel), .write(acc_write), .dma(acc_dma), .xio(mode_xio),
    .wblk(c_wblk), .eoff(c_eoff), .wcommit(c_wcom)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          region_sel    <= NREG'(1) << RG_EXT;
          block_idx     <= '0;
          write_blocked <= 1'b0;
          ext_off       <= 1'b0;
          write_commit  <= 1'b0;
        end else begin
          region_sel    <= c_sel;
          block_idx     <= c_blk;
          write_blocked <= c_wblk;
          ext_off       <= c_eoff;
          write_commit  <= c_wcom;
        end
      end
    end else begin : g_comb
      assign region_sel    = c_sel;
      assign block_idx     = c_blk;
      assign write_blocked = c_wblk;
      assign ext_off       = c_eoff;
      assign write_commit  = c_wcom;
    end
  endgenerate
endmodule

// File: rtl/pgmem_region_chk.sv
`timescale 1ns/1ps
module pgmem_region_chk
  import pgmem_pkg::*;
#(
  parameter bit REG_OUT = 1'b1,
  parameter int IDX_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       acc_space,
  input logic [NREG-1:0]  region_sel,
  input logic [IDX_W-1:0] block_idx,
  input logic             write_blocked,
  input logic             ext_off,
  input logic             write_commit
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(region_sel) == 1); // R1

  AST_BLOCK_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    write_blocked |-> (region_sel[RG_SHR] || region_sel[RG_ROM])); // R10

  AST_EXTOFF_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ext_off |-> region_sel[RG_EXT]); // R11

  AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    write_commit |-> (!write_blocked && !ext_off && !region_sel[RG_RSV])); // R12

  AST_BLK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (region_sel[RG_EXT] || region_sel[RG_ROM] || region_sel[RG_MMR] || region_sel[RG_RSV])
      |-> (block_idx == '0)); // R9

  generate
    if (REG_OUT) begin : g_seq
      AST_IO_EXTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_space[1] |=> region_sel[RG_EXT]); // R8
    end else begin : g_cmb
      AST_IO_EXTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_space[1] |-> region_sel[RG_EXT]); // R8
    end
  endgenerate
endmodule

bind pgmem_region_dec pgmem_region_chk #(.REG_OUT(REG_OUT), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_space(acc_space), .region_sel(region_sel),
  .block_idx(block_idx), .write_blocked(write_blocked), .ext_off(ext_off),
  .write_commit(write_commit)
);

// File: tb/tb_pgmem_region_dec.sv
`timescale 1ns/1ps
module tb_pgmem_region_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  acc_space = '0;
  logic [6:0]  acc_page = '0;
  logic [15:0] acc_offset = '0;
  logic        acc_write = 1'b0, acc_dma = 1'b0;
  logic        mode_ovly = 1'b0, mode_mpmc = 1'b0, mode_drom = 1'b0;
  logic        mode_romen = 1'b0, mode_xio = 1'b0;
  logic [6:0]  region_sel;
  logic [3:0]  block_idx;
  logic        write_blocked, ext_off, write_commit;
  int          checks = 0, errors = 0;
  logic [15:0] offs [8] = '{16'h0000, 16'h005F, 16'h0060, 16'h7FFF,
                            16'h8000, 16'hDFFF, 16'hE000, 16'hFFFF};

  always #2.5 clk = ~clk;

  pgmem_region_dec dut (
    .clk(clk), .rst_n(rst_n), .acc_space(acc_space), .acc_page(acc_page),
    .acc_offset(acc_offset), .acc_write(acc_write), .acc_dma(acc_dma),
    .mode_ovly(mode_ovly), .mode_mpmc(mode_mpmc), .mode_drom(mode_drom),
    .mode_romen(mode_romen), .mode_xio(mode_xio), .region_sel(region_sel),
    .block_idx(block_idx), .write_blocked(write_blocked), .ext_off(ext_off),
    .write_commit(write_commit)
  );

  // md = {xio, romen, drom, mpmc, ovly}; result = {sel[6:0], blk[3:0], wb, eo, wc}
  function automatic logic [13:0] model(input logic [1:0] sp, input logic [6:0] pg,
      input logic [15:0] off, input logic wr, input logic dm, input logic [4:0] md);
    int r = 4;
    int b = 0;
    logic wb, eo, wc;
    if (sp == 2'd0) begin
      if (off < 16'h8000) begin
        if (!md[0]) r = 4;
        else if (off <= 16'h005F) r = 6;
        else begin r = 0; b = int'(off) / 8192; end
      end else begin
        if (md[1] || pg >= 7'd4) r = 4;
        else if (md[3] && pg == 7'd0 && off >= 16'hE000) r = 3;
        else begin r = 2; b = int'(pg) * 4 + (int'(off) - 32768) / 8192; end
      end
    end else if (sp == 2'd1) begin
      if (off <= 16'h005F) r = 5;
      else if (off < 16'h8000) begin r = 0; b = int'(off) / 8192; end
      else if (md[2]) begin r = 1; b = (int'(off) - 32768) / 8192; end
      else r = 4;
    end
    wb = wr && (r == 3 || (r == 2 && !dm));
    eo = (r == 4) && !md[4];
    wc = wr && !wb && !eo && (r != 6);
    return {7'(1 << r), 4'(b), wb, eo, wc};
  endfunction

  function automatic logic [13:0] observed();
    return {region_sel, block_idx, write_blocked, ext_off, write_commit};
  endfunction

  task automatic check(input string req, input logic [13:0] got, input logic [13:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] sp, input logic [6:0] pg, input logic [15:0] off,
      input logic wr, input logic dm, input logic [4:0] md);
    acc_space = sp; acc_page = pg; acc_offset = off; acc_write = wr; acc_dma = dm;
    {mode_xio, mode_romen, mode_drom, mode_mpmc, mode_ovly} = md;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic probe(input string req, input logic [1:0] sp, input logic [6:0] pg,
      input logic [15:0] off, input logic wr, input logic dm, input logic [4:0] md);
    apply(sp, pg, off, wr, dm, md);
    check(req, observed(), model(sp, pg, off, wr, dm, md));
  endtask

  task automatic t_reset();
    apply(2'd0, 7'd0, 16'h0100, 1'b1, 1'b0, 5'b11111);
    check("R1 reset", observed(), {7'b0010000, 4'd0, 3'b000});
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_space_codes();
    probe("R2 data code", 2'd1, 7'd0, 16'h0100, 1'b0, 1'b0, 5'b10000);
    check("R2 data lda", {7'(region_sel), 7'd0}, {7'b0000001, 7'd0});
    probe("R2 io code 3", 2'd3, 7'd0, 16'h0100, 1'b0, 1'b0, 5'b10111);
    check("R2 io code 3 ext", {7'(region_sel), 7'd0}, {7'b0010000, 7'd0});
  endtask

  task automatic t_prog_low();
    for (int p = 0; p < 128; p += 37) begin
      probe("R3 ovly0", 2'd0, 7'(p), 16'h4000, 1'b0, 1'b0, 5'b10000);
      probe("R3 ovly1", 2'd0, 7'(p), 16'h6123, 1'b0, 1'b0, 5'b10001);
    end
    probe("R3 reserved", 2'd0, 7'd2, 16'h005F, 1'b1, 1'b0, 5'b10001);
    check("R3 reserved sel", {7'(region_sel), 7'd0}, {7'b1000000, 7'd0});
    check("R12 reserved no commit", {13'd0, write_commit}, 14'd0);
  endtask

  task automatic t_prog_high();
    probe("R4 shared", 2'd0, 7'd3, 16'hA000, 1'b0, 1'b0, 5'b10000);
    check("R4 shared sel", {7'(region_sel), 7'd0}, {7'b0000100, 7'd0});
    probe("R4 mpmc ext", 2'd0, 7'd1, 16'hA000, 1'b0, 1'b0, 5'b10010);
    probe("R4 page4 ext", 2'd0, 7'd4, 16'h8000, 1'b0, 1'b0, 5'b10000);
  endtask

  task automatic t_alias();
    for (int p = 8; p < 128; p += 13) begin
      probe("R5 alias", 2'd0, 7'(p), 16'hC000, 1'b0, 1'b0, 5'b10000);
      check("R5 alias ext", {7'(region_sel), 7'd0}, {7'b0010000, 7'd0});
    end
  endtask

  task automatic t_rom();
    probe("R6 rom on", 2'd0, 7'd0, 16'hE000, 1'b0, 1'b0, 5'b11000);
    check("R6 rom sel", {7'(region_sel), 7'd0}, {7'b0001000, 7'd0});
    probe("R6 rom below", 2'd0, 7'd0, 16'hDFFF, 1'b0, 1'b0, 5'b11000);
    probe("R6 rom off", 2'd0, 7'd0, 16'hFFFF, 1'b0, 1'b0, 5'b10000);
    check("R6 rom off shared", {7'(region_sel), block_idx, 3'd0}, {7'b0000100, 4'd3, 3'd0});
    probe("R6 rom page1", 2'd0, 7'd1, 16'hE000, 1'b0, 1'b0, 5'b11000);
  endtask

  task automatic t_data();
    for (int p = 0; p < 128; p += 63) begin
      probe("R7 mmr", 2'd1, 7'(p), 16'h0000, 1'b1, 1'b0, 5'b00000);
      probe("R7 lda", 2'd1, 7'(p), 16'h0060, 1'b0, 1'b0, 5'b00000);
      probe("R7 drom1", 2'd1, 7'(p), 16'hF000, 1'b0, 1'b0, 5'b10100);
      probe("R7 drom0", 2'd1, 7'(p), 16'hF000, 1'b0, 1'b0, 5'b10000);
    end
  endtask

  task automatic t_io();
    for (int m = 0; m < 32; m += 5)
      probe("R8 io", 2'd2, 7'(m), 16'(m * 2039), 1'b0, 1'b0, 5'(m));
  endtask

  task automatic t_blocks();
    probe("R9 shared idx", 2'd0, 7'd2, 16'hC000, 1'b0, 1'b0, 5'b10000);
    check("R9 shared idx val", {7'd0, block_idx, 3'd0}, {7'd0, 4'd10, 3'd0});
    probe("R9 lda idx", 2'd0, 7'd0, 16'h7FFF, 1'b0, 1'b0, 5'b10001);
    check("R9 lda idx val", {7'd0, block_idx, 3'd0}, {7'd0, 4'd3, 3'd0});
    probe("R9 lsa idx", 2'd1, 7'd0, 16'hA000, 1'b0, 1'b0, 5'b10100);
  endtask

  task automatic t_writes();
    probe("R10 cpu shared", 2'd0, 7'd1, 16'h9000, 1'b1, 1'b0, 5'b10000);
    check("R10 cpu blocked", {11'd0, write_blocked, 2'd0}, {11'd0, 1'b1, 2'd0});
    probe("R10 dma shared", 2'd0, 7'd1, 16'h9000, 1'b1, 1'b1, 5'b10000);
    check("R12 dma commit", {13'd0, write_commit}, 14'd1);
    probe("R10 dma rom", 2'd0, 7'd0, 16'hF000, 1'b1, 1'b1, 5'b11000);
    probe("R12 mmr write", 2'd1, 7'd0, 16'h0010, 1'b1, 1'b0, 5'b00000);
  endtask

  task automatic t_xio();
    probe("R11 ext read off", 2'd2, 7'd0, 16'h1234, 1'b0, 1'b0, 5'b00000);
    check("R11 flag", {12'd0, ext_off, 1'b0}, {12'd0, 1'b1, 1'b0});
    probe("R11 ext write off", 2'd0, 7'd5, 16'h9000, 1'b1, 1'b0, 5'b00000);
    probe("R11 ext write on", 2'd0, 7'd5, 16'h9000, 1'b1, 1'b0, 5'b10000);
  endtask

  task automatic t_sweep();
    for (int p = 0; p < 128; p++)
      for (int m = 0; m < 32; m++)
        for (int k = 0; k < 8; k++)
          probe("R3-sweep prog", 2'd0, 7'(p), offs[k], k[0], p[1], 5'(m));
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 32; m++)
        for (int k = 0; k < 8; k++)
          probe("R7 R8 sweep", 2'(s), 7'(m * 4), offs[k], m[0], k[0], 5'(m));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_space_codes();
    t_prog_low();
    t_prog_high();
    t_alias();
    t_rom();
    t_data();
    t_io();
    t_blocks();
    t_writes();
    t_xio();
    t_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule